// File: doc/BRIEF.md
# Multiple-Word Register Transfer Sequencer

This block moves a contiguous run of general registers to memory, or fills that run from memory. It handles one 32-bit word per clock. The caller supplies five operands: the first register of the run, the number and current value of a base register, a signed 16-bit displacement, and a direction bit. The run always ends at the highest register (31), so the first register number sets the number of words. A run that starts at register `f` moves `32 - f` words.

The first word is at the base value plus the sign-extended displacement. When the base register number is zero, the base value is replaced by a literal zero. Each later word is 4 bytes above the one before it, and each later register number is one above the one before it.

The block drives a word-wide memory port and a register-file port. Both ports read combinationally. While a run is in progress, `busy_o` stays high. A one-cycle `done_o` pulse follows the last word. A start request is refused in two cases, and in both cases the block pulses `err_o` for one cycle and makes no transfer:
- the effective address is not word-aligned;
- a load names a first register that is not above the base register.

Top module: `lsm_seq`

## Requirements
- R1: The first transfer uses address = (base_reg_i == 0 ? 0 : base_val_i) + sign-extended disp_i, computed modulo 2^32.
- R2: An accepted run has one busy cycle per register, from first_reg_i up to 31 in steps of one, so it makes exactly 32 - first_reg_i transfers.
- R3: The address of each transfer after the first is the previous address plus 4.
- R4: If the effective address has either of its low two bits set, err_o is high for exactly the one cycle after the start. In that case busy_o, mem_we_o and rf_we_o stay low.
- R5: A load (is_load_i = 1) with first_reg_i <= base_reg_i is rejected in the same way as R4. A store with first_reg_i <= base_reg_i is accepted.
- R6: In a store cycle, mem_we_o = 1, rf_raddr_o holds the current register number, mem_wdata_o equals rf_rdata_i, and rf_we_o = 0.
- R7: In a load cycle, rf_we_o = 1, rf_waddr_o holds the current register number, rf_wdata_o equals mem_rdata_i, and mem_we_o = 0.
- R8: busy_o rises in the cycle after an accepted start. done_o is high for exactly the cycle after the last transfer, and busy_o is low in that cycle. start_i is ignored while busy_o is high.
- R9: The base value is sampled only when a start is accepted, so changes to base_val_i during a run do not alter the run's addresses.
- R10: After reset, busy_o, done_o, err_o, mem_we_o and rf_we_o are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start request, sampled while idle |
| is_load_i | input | 1 | 1 = memory to registers, 0 = registers to memory |
| first_reg_i | input | 5 | First register of the run |
| base_reg_i | input | 5 | Base register number (0 means literal zero) |
| base_val_i | input | 32 | Current value of the base register |
| disp_i | input | 16 | Signed displacement |
| mem_addr_o | output | 32 | Word address of the current transfer |
| mem_wdata_o | output | 32 | Store data |
| mem_we_o | output | 1 | Memory write enable |
| mem_rdata_i | input | 32 | Memory read data (combinational) |
| rf_raddr_o | output | 5 | Register-file read index |
| rf_rdata_i | input | 32 | Register-file read data (combinational) |
| rf_waddr_o | output | 5 | Register-file write index |
| rf_wdata_o | output | 32 | Register-file write data |
| rf_we_o | output | 1 | Register-file write enable |
| busy_o | output | 1 | Run in progress |
| done_o | output | 1 | One-cycle pulse after the last word |
| err_o | output | 1 | One-cycle pulse on a rejected start |

## Verification
Two cases place two events close together in time:

- **Run ending and next request.** The last transfer of a run happens in the cycle just before `done_o`. A second start request can arrive while the first run is still in progress.
- **Base register changing mid-run.** During a load, the base register could in principle be rewritten while the run continues.

The bench provokes the first case by pulsing `start_i` with different operands in the middle of some runs. It also changes `base_val_i` in the cycle after acceptance. Every cycle's address and register index is then checked against arithmetic built from the original operands only.

Runs that start at register 31 make the first transfer and the final step fall in the same busy cycle. For these, the bench checks that `done_o` rises in the next cycle, which is also the cycle where a fresh start is first accepted.

// File: rtl/lsm_seq.sv
module lsm_seq #(
  parameter int DW    = 32,
  parameter int AW    = 32,
  parameter int DISPW = 16,
  parameter int RW    = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_i,
  input  logic          is_load_i,
  input  logic [RW-1:0] first_reg_i,
  input  logic [RW-1:0] base_reg_i,
  input  logic [AW-1:0] base_val_i,
  input  logic [DISPW-1:0] disp_i,
  output logic [AW-1:0] mem_addr_o,
  output logic [DW-1:0] mem_wdata_o,
  output logic          mem_we_o,
  input  logic [DW-1:0] mem_rdata_i,
  output logic [RW-1:0] rf_raddr_o,
  input  logic [DW-1:0] rf_rdata_i,
  output logic [RW-1:0] rf_waddr_o,
  output logic [DW-1:0] rf_wdata_o,
  output logic          rf_we_o,
  output logic          busy_o,
  output logic          done_o,
  output logic          err_o
);

  localparam logic [RW-1:0] LAST_REG = {RW{1'b1}};
  localparam logic [AW-1:0] STEP     = AW'(DW / 8);

  logic          busy_q, done_q, err_q, load_q;
  logic [RW-1:0] cur_q;
  logic [AW-1:0] addr_q;

  wire [AW-1:0] base_eff = (base_reg_i == '0) ? '0 : base_val_i;
  wire [AW-1:0] disp_ext = {{(AW-DISPW){disp_i[DISPW-1]}}, disp_i};
  wire [AW-1:0] ea       = base_eff + disp_ext;
  wire          misalign = |ea[1:0];
  wire          overlap  = is_load_i && (first_reg_i <= base_reg_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      load_q <= 1'b0;
      cur_q  <= '0;
      addr_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      if (busy_q) begin
        if (cur_q == LAST_REG) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end else begin
          cur_q  <= cur_q + 1'b1;
          addr_q <= addr_q + STEP;
        end
      end else if (start_i) begin
        if (misalign || overlap) begin
          err_q <= 1'b1;
        end else begin
          busy_q <= 1'b1;
          load_q <= is_load_i;
          cur_q  <= first_reg_i;
          addr_q <= ea;
        end
      end
    end
  end

  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = rf_rdata_i;
  assign mem_we_o    = busy_q & ~load_q;
  assign rf_raddr_o  = cur_q;
  assign rf_waddr_o  = cur_q;
  assign rf_wdata_o  = mem_rdata_i;
  assign rf_we_o     = busy_q & load_q;
  assign busy_o      = busy_q;
  assign done_o      = done_q;
  assign err_o       = err_q;

  p_addr_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> mem_addr_o == $past(mem_addr_o) + STEP);

  p_reg_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && $past(busy_o) |-> rf_raddr_o == $past(rf_raddr_o) + 1'b1);

  p_aligned_r4: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o |-> mem_addr_o[1:0] == 2'b00);

  p_err_quiet_r5: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> !busy_o && !mem_we_o && !rf_we_o);

  p_done_after_last_r8: assert property (@(posedge clk) disable iff (!rst_n)
    busy_o && rf_raddr_o == LAST_REG |=> done_o && !busy_o);

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  p_one_direction_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_we_o && rf_we_o));

endmodule

// File: tb/lsm_seq_tb.sv
module lsm_seq_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0, is_load_i = 1'b0;
  logic [4:0] first_reg_i = '0, base_reg_i = '0;
  logic [31:0] base_val_i = '0;
  logic [15:0] disp_i = '0;
  logic [31:0] mem_addr_o, mem_wdata_o, mem_rdata_i, rf_rdata_i, rf_wdata_o;
  logic mem_we_o, rf_we_o, busy_o, done_o, err_o;
  logic [4:0] rf_raddr_o, rf_waddr_o;

  logic [31:0] mem [0:1023];
  logic [31:0] regs [0:31];
  int tests = 0, fails = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  lsm_seq dut_i (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .is_load_i(is_load_i),
    .first_reg_i(first_reg_i), .base_reg_i(base_reg_i), .base_val_i(base_val_i),
    .disp_i(disp_i), .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o),
    .mem_we_o(mem_we_o), .mem_rdata_i(mem_rdata_i), .rf_raddr_o(rf_raddr_o),
    .rf_rdata_i(rf_rdata_i), .rf_waddr_o(rf_waddr_o), .rf_wdata_o(rf_wdata_o),
    .rf_we_o(rf_we_o), .busy_o(busy_o), .done_o(done_o), .err_o(err_o));

  assign mem_rdata_i = mem[mem_addr_o[11:2]];
  assign rf_rdata_i  = regs[rf_raddr_o];

  always @(posedge clk) begin
    if (mem_we_o) mem[mem_addr_o[11:2]] <= mem_wdata_o;
    if (rf_we_o)  regs[rf_waddr_o] <= rf_wdata_o;
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic fill(input int seed);
    for (int i = 0; i < 1024; i++) mem[i] = 32'hA500_0000 ^ (i * 32'h0001_0101) ^ seed;
    for (int k = 0; k < 32; k++) regs[k] = 32'h5A00_0000 + k * 32'h11 + seed * 32'h1000;
  endtask

  task automatic run(input bit ld, input int f, input int br, input logic [31:0] bv,
                     input logic [15:0] d, input bit poke);
    logic [31:0] ea, snap [0:31];
    int n;
    ea = ((br == 0) ? 32'd0 : bv) + {{16{d[15]}}, d};
    n = 32 - f;
    for (int k = 0; k < 32; k++) snap[k] = ld ? mem[(ea[11:2] + k - f) & 1023] : regs[k];
    @(negedge clk);
    start_i = 1; is_load_i = ld; first_reg_i = 5'(f); base_reg_i = 5'(br);
    base_val_i = bv; disp_i = d;
    @(negedge clk);
    start_i = 0;
    if (poke) base_val_i = 32'hDEAD_0000;
    for (int i = 0; i < n; i++) begin
      check(busy_o && !done_o, "R8 busy during run", {30'd0, busy_o, done_o}, 32'h2);
      check(mem_addr_o == ea + 32'(4 * i), "R1/R3 address", mem_addr_o, ea + 32'(4 * i));
      check(rf_raddr_o == 5'(f + i) && rf_waddr_o == 5'(f + i), "R2 register index",
            {27'd0, rf_raddr_o}, 32'(f + i));
      if (ld) check(rf_we_o && !mem_we_o && rf_wdata_o == mem[mem_addr_o[11:2]],
                    "R7 load cycle", rf_wdata_o, mem[mem_addr_o[11:2]]);
      else    check(mem_we_o && !rf_we_o && mem_wdata_o == regs[f + i],
                    "R6 store cycle", mem_wdata_o, regs[f + i]);
      if (poke && i == 1) begin
        start_i = 1; is_load_i = ~ld; first_reg_i = 5'd3; base_reg_i = 5'd0; disp_i = 16'h0100;
      end else begin
        start_i = 0;
      end
      @(negedge clk);
    end
    start_i = 0;
    check(done_o && !busy_o, "R8 done after last word", {30'd0, busy_o, done_o}, 32'h1);
    check(!mem_we_o && !rf_we_o, "R8 no transfer after run", {30'd0, mem_we_o, rf_we_o}, 32'h0);
    @(negedge clk);
    check(!done_o && !busy_o, "R8 done single pulse", {30'd0, busy_o, done_o}, 32'h0);
    for (int k = f; k < 32; k++) begin
      if (ld) check(regs[k] == snap[k], "R7 register loaded", regs[k], snap[k]);
      else    check(mem[(ea[11:2] + k - f) & 1023] == snap[k], "R6 word stored",
                    mem[(ea[11:2] + k - f) & 1023], snap[k]);
    end
  endtask

  task automatic reject(input bit ld, input int f, input int br, input logic [31:0] bv,
                        input logic [15:0] d, input string req);
    @(negedge clk);
    start_i = 1; is_load_i = ld; first_reg_i = 5'(f); base_reg_i = 5'(br);
    base_val_i = bv; disp_i = d;
    @(negedge clk);
    start_i = 0;
    check(err_o && !busy_o && !mem_we_o && !rf_we_o, req, {28'd0, err_o, busy_o, mem_we_o, rf_we_o}, 32'h8);
    @(negedge clk);
    check(!err_o && !busy_o && !mem_we_o && !rf_we_o, {req, " single pulse"},
          {28'd0, err_o, busy_o, mem_we_o, rf_we_o}, 32'h0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++; tests++;
      $display("FAIL R8 watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    fill(0);
    repeat (3) @(negedge clk);
    check(!busy_o && !done_o && !err_o && !mem_we_o && !rf_we_o, "R10 reset state",
          {27'd0, busy_o, done_o, err_o, mem_we_o, rf_we_o}, 32'h0);
    rst_n = 1;
    @(negedge clk);
    // R6 / R2: stores from every first register, with and without a base register
    for (int f = 0; f < 32; f++) begin
      fill(f);
      run(0, f, 7, 32'h0000_0400, 16'(4 * f - 64), (f % 3) == 0);
      run(0, f, 0, 32'hFFFF_0000, 16'(32'h200 + 4 * f), (f % 4) == 1);
    end
    // R5: store with first register not above base is accepted
    fill(99);
    run(0, 4, 20, 32'h0000_0300, 16'hFFF0, 0);
    // R7 / R9: loads from every legal first register
    for (int f = 1; f < 32; f++) begin
      fill(f + 40);
      run(1, f, f - 1, 32'h0000_0800, 16'(-4 * f), (f % 2) == 0);
      run(1, f, 0, 32'h1234_5678, 16'(32'h180 + 8 * f), (f % 5) == 2);
    end
    // R4: misaligned effective addresses
    for (int m = 1; m < 4; m++) begin
      reject(0, 10, 3, 32'h0000_0400, 16'(m), "R4 misaligned store");
      reject(1, 10, 3, 32'h0000_0400, 16'(8 + m), "R4 misaligned load");
      reject(0, 2, 5, 32'h0000_0401, 16'(m - 1), "R4 misaligned base");
    end
    // R5: load start register not above base register
    reject(1, 9, 9, 32'h0000_0400, 16'h0, "R5 load first equals base");
    reject(1, 4, 12, 32'h0000_0400, 16'h0, "R5 load first below base");
    reject(1, 0, 0, 32'h0000_0000, 16'h0100, "R5 load from register 0");
    // a normal run after rejects still works
    fill(7);
    run(1, 28, 2, 32'h0000_0200, 16'h0040, 0);
    finished = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule